// File: doc/BRIEF.md
# Audio Sample-Rate Strobe Generator

This block turns a fast master clock into the sample-rate ticks of an audio converter pair. It first divides the master clock by 128·Q to make a reference frame tick. From that tick it makes two more, one for the playback path and one for the record path. Each path has its own divide ratio, and two of the ratios are half-integers. Each tick is high for one master-clock cycle. The downstream converter logic uses the ticks as clock enables.

Each path counts master-clock cycles on its own counter. The full period 128·Q·N is always a whole number of cycles, so the fractional ratios 1.5 and 5.5 come out with no jitter. A small register port sets Q, both ratio codes and a global enable. Any write restarts every counter. An illegal setting raises an error flag and holds the affected ticks low until a write makes the setting legal again.

A four-state controller picks which counters may run. The states are:
- `ST_OFF`: the enable is low.
- `ST_RUN_ALL`: all three paths are legal and run.
- `ST_RUN_PLAY`: Q is legal but the record setting is not, so only the reference and playback ticks run.
- `ST_HALT`: Q is outside its range.

The next state depends only on the configuration that results from the current cycle's write. Any state can move to any other:
- "disable" goes to `ST_OFF`.
- "arm" goes to `ST_RUN_ALL`.
- "record fault" goes to `ST_RUN_PLAY`.
- "range fault" goes to `ST_HALT`.

Top module: `smp_rate_strobe_gen`

## Requirements
- R1: A write with `cfg_we` high uses `cfg_addr` to pick the target. Address 0 takes Q from all bits of `cfg_wdata`. Address 1 takes the playback code from bits [2:0]. Address 2 takes the record code from bits [2:0]. Address 3 takes the enable from bit 0. Reset sets Q to 2, both codes to 0 and the enable to 0, and every output reads low after reset.
- R2: While the enable is set and Q is between 2 and 17, `fs_stb_o` pulses every 128·Q master-clock cycles.
- R3: The playback tick pulses every 128·Q·N1 cycles. The code maps as 000→1, 001→1.5, 010→2, 011→3, 100→4, 101→5, 110→5.5, 111→6.
- R4: The record tick pulses every 128·Q·N2 cycles, using the same code map. Its ratio is independent of the playback ratio.
- R5: The half-integer ratios give exactly 192·Q cycles (code 001) and 704·Q cycles (code 110) between ticks, with every interval equal.
- R6: Each tick stays high for exactly one master-clock cycle.
- R7: With the enable at 0, no tick is produced.
- R8: An odd Q with record code 001 or 110 raises `cfg_err_o` and holds `rec_stb_o` low. The reference and playback ticks keep running.
- R9: A Q below 2 or above 17 raises `cfg_err_o` and holds all three ticks low.
- R10: `cfg_err_o` changes only on a write. It stays high until a write leaves a legal configuration, and it then reads low from the cycle after that write.
- R11: Every write clears all counters. The first tick of each running path appears exactly one full new period after the write edge, so a write in the middle of a period restarts it.
- R12: With playback code 000, `play_stb_o` matches `fs_stb_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | Q_W (5) | Write data |
| fs_stb_o | output | 1 | Reference frame tick |
| play_stb_o | output | 1 | Playback sample tick |
| rec_stb_o | output | 1 | Record sample tick |
| cfg_err_o | output | 1 | Illegal configuration flag |

## Verification
The assertions rely on a few properties of this block:
- `cfg_addr` and `cfg_wdata` only matter in cycles where `cfg_we` is high.
- A tick period is never shorter than 256 cycles, so a high tick is always followed by a low one.
- The 3-bit code fields keep their positions.

The stimulus drives every write through one task that holds `cfg_we` for exactly one edge and changes inputs only on falling clock edges. It sends the enable write last in each setup sequence, so every measured period starts from a known restart edge.

// File: rtl/srsg_pkg.sv
package srsg_pkg;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_RUN_ALL  = 2'd1,
        ST_RUN_PLAY = 2'd2,
        ST_HALT     = 2'd3
    } srsg_state_t;

    localparam logic [1:0] ADDR_Q     = 2'd0;
    localparam logic [1:0] ADDR_PLAY  = 2'd1;
    localparam logic [1:0] ADDR_REC   = 2'd2;
    localparam logic [1:0] ADDR_EN    = 2'd3;

    localparam int NPATH     = 3;
    localparam int PATH_FS   = 0;
    localparam int PATH_PLAY = 1;
    localparam int PATH_REC  = 2;

    // Twice the divide ratio selected by a 3-bit code, so that half steps are integers.
    function automatic int ratio_x2(input logic [2:0] code);
        int r;
        unique case (code)
            3'b000:  r = 2;
            3'b001:  r = 3;
            3'b010:  r = 4;
            3'b011:  r = 6;
            3'b100:  r = 8;
            3'b101:  r = 10;
            3'b110:  r = 11;
            3'b111:  r = 12;
            default: r = 2;
        endcase
        return r;
    endfunction

    // Codes whose ratio has a half step.
    function automatic logic is_half_ratio(input logic [2:0] code);
        return (code == 3'b001) || (code == 3'b110);
    endfunction

endpackage

// File: rtl/srsg_cfg_ctrl.sv
module srsg_cfg_ctrl
    import srsg_pkg::*;
#(
    parameter int Q_W   = 5,
    parameter int Q_MIN = 2,
    parameter int Q_MAX = 17
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_addr,
    input  logic [Q_W-1:0] cfg_wdata,
    output logic [Q_W-1:0] q_o,
    output logic [2:0]     play_code_o,
    output logic [2:0]     rec_code_o,
    output logic           en_o,
    output logic           q_bad_o,
    output logic           run_fs_o,
    output logic           run_play_o,
    output logic           run_rec_o,
    output logic           err_o
);

    logic [Q_W-1:0] q_r, q_nx;
    logic [2:0]     pc_r, pc_nx;
    logic [2:0]     rc_r, rc_nx;
    logic           en_r, en_nx;
    logic           q_ok_nx;
    logic           rec_ok_nx;
    srsg_state_t    state_r, state_nx;

    // Configuration as it stands after this cycle's write.
    always_comb begin
        q_nx  = q_r;
        pc_nx = pc_r;
        rc_nx = rc_r;
        en_nx = en_r;
        if (cfg_we) begin
            unique case (cfg_addr)
                ADDR_Q:    q_nx  = cfg_wdata;
                ADDR_PLAY: pc_nx = cfg_wdata[2:0];
                ADDR_REC:  rc_nx = cfg_wdata[2:0];
                ADDR_EN:   en_nx = cfg_wdata[0];
                default:   q_nx  = q_r;
            endcase
        end
    end

    always_comb begin
        q_ok_nx   = (int'(q_nx) >= Q_MIN) && (int'(q_nx) <= Q_MAX);
        rec_ok_nx = !(q_nx[0] && is_half_ratio(rc_nx));
    end

    // Next state: disable / range fault / record fault / arm.
    always_comb begin
        if (!en_nx) begin
            state_nx = ST_OFF;
        end else if (!q_ok_nx) begin
            state_nx = ST_HALT;
        end else if (!rec_ok_nx) begin
            state_nx = ST_RUN_PLAY;
        end else begin
            state_nx = ST_RUN_ALL;
        end
    end

    // State and configuration registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_r <= ST_OFF;
            q_r     <= Q_W'(Q_MIN);
            pc_r    <= 3'b000;
            rc_r    <= 3'b000;
            en_r    <= 1'b0;
        end else begin
            state_r <= state_nx;
            q_r     <= q_nx;
            pc_r    <= pc_nx;
            rc_r    <= rc_nx;
            en_r    <= en_nx;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        run_fs_o   = 1'b0;
        run_play_o = 1'b0;
        run_rec_o  = 1'b0;
        err_o      = 1'b0;
        unique case (state_r)
            ST_OFF: begin
                err_o = 1'b0;
            end
            ST_RUN_ALL: begin
                run_fs_o   = 1'b1;
                run_play_o = 1'b1;
                run_rec_o  = 1'b1;
            end
            ST_RUN_PLAY: begin
                run_fs_o   = 1'b1;
                run_play_o = 1'b1;
                err_o      = 1'b1;
            end
            ST_HALT: begin
                err_o = 1'b1;
            end
            default: begin
                err_o = 1'b1;
            end
        endcase
    end

    assign q_o         = q_r;
    assign play_code_o = pc_r;
    assign rec_code_o  = rc_r;
    assign en_o        = en_r;
    assign q_bad_o     = (int'(q_r) < Q_MIN) || (int'(q_r) > Q_MAX);

endmodule

// File: rtl/srsg_period_calc.sv
module srsg_period_calc
    import srsg_pkg::*;
#(
    parameter int Q_W       = 5,
    parameter int FRAME_DIV = 128,
    parameter int CNT_W     = 14
) (
    input  logic [Q_W-1:0]   q_i,
    input  logic [2:0]       code_i,
    output logic [CNT_W-1:0] period_o
);

    localparam int HALF_DIV = FRAME_DIV / 2;

    // Full period in master-clock cycles: (FRAME_DIV/2) * Q * (2N).
    always_comb begin
        period_o = CNT_W'(HALF_DIV * int'(q_i) * ratio_x2(code_i));
    end

endmodule

// File: rtl/srsg_rate_ctr.sv
module srsg_rate_ctr #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             stb_o
);

    logic [CNT_W-1:0] cnt_r;
    logic             wrap;

    assign wrap = (cnt_r == (period_i - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || clr_i || !run_i) begin
            cnt_r <= '0;
            stb_o <= 1'b0;
        end else if (wrap) begin
            cnt_r <= '0;
            stb_o <= 1'b1;
        end else begin
            cnt_r <= cnt_r + 1'b1;
            stb_o <= 1'b0;
        end
    end

endmodule

// File: rtl/smp_rate_strobe_gen.sv
module smp_rate_strobe_gen
    import srsg_pkg::*;
#(
    parameter int Q_W       = 5,
    parameter int Q_MIN     = 2,
    parameter int Q_MAX     = 17,
    parameter int FRAME_DIV = 128
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_addr,
    input  logic [Q_W-1:0] cfg_wdata,
    output logic           fs_stb_o,
    output logic           play_stb_o,
    output logic           rec_stb_o,
    output logic           cfg_err_o
);

    localparam int PERIOD_MAX = FRAME_DIV * Q_MAX * 6;
    localparam int CNT_W      = $clog2(PERIOD_MAX + 1);

    logic [Q_W-1:0]   q_w;
    logic [2:0]       pcode_w;
    logic [2:0]       rcode_w;
    logic             en_w;
    logic             q_bad_w;
    logic             run_fs_w, run_play_w, run_rec_w;

    logic [2:0]       code_a   [NPATH];
    logic             run_a    [NPATH];
    logic [CNT_W-1:0] period_a [NPATH];
    logic             stb_a    [NPATH];

    srsg_cfg_ctrl #(
        .Q_W   (Q_W),
        .Q_MIN (Q_MIN),
        .Q_MAX (Q_MAX)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .q_o         (q_w),
        .play_code_o (pcode_w),
        .rec_code_o  (rcode_w),
        .en_o        (en_w),
        .q_bad_o     (q_bad_w),
        .run_fs_o    (run_fs_w),
        .run_play_o  (run_play_w),
        .run_rec_o   (run_rec_w),
        .err_o       (cfg_err_o)
    );

    // The reference path is a path with unity ratio.
    always_comb begin
        code_a[PATH_FS]   = 3'b000;
        code_a[PATH_PLAY] = pcode_w;
        code_a[PATH_REC]  = rcode_w;
        run_a[PATH_FS]    = run_fs_w;
        run_a[PATH_PLAY]  = run_play_w;
        run_a[PATH_REC]   = run_rec_w;
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        srsg_period_calc #(
            .Q_W       (Q_W),
            .FRAME_DIV (FRAME_DIV),
            .CNT_W     (CNT_W)
        ) u_per (
            .q_i      (q_w),
            .code_i   (code_a[p]),
            .period_o (period_a[p])
        );

        srsg_rate_ctr #(
            .CNT_W (CNT_W)
        ) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .clr_i    (cfg_we),
            .run_i    (run_a[p]),
            .period_i (period_a[p]),
            .stb_o    (stb_a[p])
        );
    end

    assign fs_stb_o   = stb_a[PATH_FS];
    assign play_stb_o = stb_a[PATH_PLAY];
    assign rec_stb_o  = stb_a[PATH_REC];

endmodule

// File: rtl/srsg_checker.sv
module srsg_checker (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic       fs_stb_o,
    input logic       play_stb_o,
    input logic       rec_stb_o,
    input logic       cfg_err_o,
    input logic       en_w,
    input logic       q_bad_w,
    input logic [2:0] pcode_w
);

    assert_fs_single_R6: assert property (@(posedge clk) disable iff (rst)
        fs_stb_o |=> !fs_stb_o);
    assert_play_single_R6: assert property (@(posedge clk) disable iff (rst)
        play_stb_o |=> !play_stb_o);
    assert_rec_single_R6: assert property (@(posedge clk) disable iff (rst)
        rec_stb_o |=> !rec_stb_o);

    assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        !en_w |-> !(fs_stb_o || play_stb_o || rec_stb_o));

    assert_rec_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |-> !rec_stb_o);

    assert_range_halt_R9: assert property (@(posedge clk) disable iff (rst)
        (en_w && q_bad_w) |-> !(fs_stb_o || play_stb_o) && cfg_err_o);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_err_o));

    assert_write_restart_R11: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> !(fs_stb_o || play_stb_o || rec_stb_o));

    assert_unity_match_R12: assert property (@(posedge clk) disable iff (rst)
        (pcode_w == 3'b000) |-> (play_stb_o == fs_stb_o));

endmodule

bind smp_rate_strobe_gen srsg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .fs_stb_o   (fs_stb_o),
    .play_stb_o (play_stb_o),
    .rec_stb_o  (rec_stb_o),
    .cfg_err_o  (cfg_err_o),
    .en_w       (en_w),
    .q_bad_w    (q_bad_w),
    .pcode_w    (pcode_w)
);

// File: tb/tb_smp_rate_strobe_gen.sv
module tb_smp_rate_strobe_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [4:0] cfg_wdata = 5'd0;
    logic       fs_stb_o, play_stb_o, rec_stb_o, cfg_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int n_a  [3];
    int t1_a [3];
    int t2_a [3];
    int dbl;
    int coin_bad;
    int err_bad;

    always #5 clk = ~clk;

    smp_rate_strobe_gen dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .fs_stb_o   (fs_stb_o),
        .play_stb_o (play_stb_o),
        .rec_stb_o  (rec_stb_o),
        .cfg_err_o  (cfg_err_o)
    );

    // {q[5], play code[3], rec code[3], fs period[16], play period[16], rec period[16], err[1]}
    // A period of 0 means no tick is expected.
    localparam int NVEC = 9;
    localparam logic [59:0] VEC [NVEC] = '{
        {5'd2,  3'd0, 3'd2, 16'd256,  16'd256,   16'd512,  1'b0},
        {5'd3,  3'd1, 3'd7, 16'd384,  16'd576,   16'd2304, 1'b0},
        {5'd4,  3'd6, 3'd1, 16'd512,  16'd2816,  16'd768,  1'b0},
        {5'd3,  3'd3, 3'd1, 16'd384,  16'd1152,  16'd0,    1'b1},
        {5'd5,  3'd4, 3'd6, 16'd640,  16'd2560,  16'd0,    1'b1},
        {5'd1,  3'd0, 3'd0, 16'd0,    16'd0,     16'd0,    1'b1},
        {5'd18, 3'd2, 3'd2, 16'd0,    16'd0,     16'd0,    1'b1},
        {5'd17, 3'd5, 3'd3, 16'd2176, 16'd10880, 16'd6528, 1'b0},
        {5'd6,  3'd1, 3'd6, 16'd768,  16'd1152,  16'd4224, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [4:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Sample index i is the falling edge after the i-th rising edge past the last write.
    task automatic observe(input int win, input bit exp_err, input bit unity);
        logic prev [3];
        logic cur  [3];
        for (int k = 0; k < 3; k++) begin
            n_a[k] = 0; t1_a[k] = 0; t2_a[k] = 0; prev[k] = 1'b0;
        end
        dbl = 0; coin_bad = 0; err_bad = 0;
        for (int i = 1; i <= win; i++) begin
            @(negedge clk);
            cur[0] = fs_stb_o; cur[1] = play_stb_o; cur[2] = rec_stb_o;
            for (int k = 0; k < 3; k++) begin
                if (cur[k]) begin
                    n_a[k]++;
                    if (n_a[k] == 1) t1_a[k] = i;
                    else if (n_a[k] == 2) t2_a[k] = i;
                    if (prev[k]) dbl++;
                end
                prev[k] = cur[k];
            end
            if (unity && (play_stb_o != fs_stb_o)) coin_bad++;
            if (cfg_err_o != exp_err) err_bad++;
        end
    endtask

    task automatic chk_path(input int k, input int per, input string req);
        if (per == 0) begin
            chk(n_a[k] == 0, req, "tick count when blocked", n_a[k], 0);
        end else begin
            chk(t1_a[k] == per, req, "first tick after write (R11)", t1_a[k], per);
            chk(t2_a[k] == 2 * per, req, "second tick", t2_a[k], 2 * per);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, then quiet with enable cleared
        observe(600, 1'b0, 1'b0);
        chk(n_a[0] + n_a[1] + n_a[2] == 0, "R1", "ticks after reset", n_a[0] + n_a[1] + n_a[2], 0);
        chk(err_bad == 0, "R1", "error flag after reset", err_bad, 0);

        // Table-driven configurations
        for (int v = 0; v < NVEC; v++) begin
            logic [4:0] q;
            logic [2:0] pc, rc;
            int pf, pp, pr, win, mx;
            logic ee;
            q  = VEC[v][59:55];
            pc = VEC[v][54:52];
            rc = VEC[v][51:49];
            pf = int'(VEC[v][48:33]);
            pp = int'(VEC[v][32:17]);
            pr = int'(VEC[v][16:1]);
            ee = VEC[v][0];
            mx = pf;
            if (pp > mx) mx = pp;
            if (pr > mx) mx = pr;
            win = (mx == 0) ? 2000 : 2 * mx + 4;
            wr(2'd0, q);
            wr(2'd1, {2'b00, pc});
            wr(2'd2, {2'b00, rc});
            wr(2'd3, 5'd1);
            observe(win, ee, pc == 3'd0);
            chk_path(0, pf, (pf == 0) ? "R9" : "R2");
            chk_path(1, pp, (pp == 0) ? "R9" : ((pc == 3'd1 || pc == 3'd6) ? "R5" : "R3"));
            chk_path(2, pr, (q < 5'd2 || q > 5'd17) ? "R9" : (pr == 0) ? "R8" :
                            ((rc == 3'd1 || rc == 3'd6) ? "R5" : "R4"));
            chk(dbl == 0, "R6", "back-to-back tick cycles", dbl, 0);
            chk(err_bad == 0, ee ? "R10" : "R8", "cycles with wrong error flag", err_bad, 0);
            if (pc == 3'd0) chk(coin_bad == 0, "R12", "unity playback mismatch cycles", coin_bad, 0);
        end

        // R7: enable cleared stops everything
        wr(2'd0, 5'd2);
        wr(2'd1, 5'd0);
        wr(2'd2, 5'd0);
        wr(2'd3, 5'd0);
        observe(1500, 1'b0, 1'b1);
        chk(n_a[0] + n_a[1] + n_a[2] == 0, "R7", "ticks while disabled", n_a[0] + n_a[1] + n_a[2], 0);

        // R11: a write in mid-period restarts the count
        wr(2'd3, 5'd1);
        repeat (100) @(negedge clk);
        wr(2'd1, 5'd0);
        observe(300, 1'b0, 1'b1);
        chk(t1_a[0] == 256, "R11", "fs tick after mid-period write", t1_a[0], 256);
        chk(n_a[0] == 1, "R11", "fs ticks in window", n_a[0], 1);

        // R10: flag holds until a legal record code, then clears
        wr(2'd0, 5'd3);
        wr(2'd2, 5'd1);
        observe(1000, 1'b1, 1'b1);
        chk(err_bad == 0, "R10", "flag low cycles while illegal", err_bad, 0);
        chk(n_a[2] == 0, "R8", "record ticks while illegal", n_a[2], 0);
        chk(n_a[0] == 2, "R8", "fs keeps running while record blocked", n_a[0], 2);
        wr(2'd2, 5'd2);
        observe(1540, 1'b0, 1'b1);
        chk(err_bad == 0, "R10", "flag high cycles after legal write", err_bad, 0);
        chk(t1_a[2] == 768, "R10", "record first tick after recovery", t1_a[2], 768);

        // R1: synchronous reset mid-run returns to defaults
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        observe(600, 1'b0, 1'b1);
        chk(n_a[0] + n_a[1] + n_a[2] == 0, "R1", "ticks after mid-run reset", n_a[0] + n_a[1] + n_a[2], 0);
        wr(2'd3, 5'd1);
        observe(260, 1'b0, 1'b1);
        chk(t1_a[0] == 256, "R1", "default Q gives 256-cycle frame", t1_a[0], 256);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule